// File: doc/BRIEF.md
# Unlock-Cycle NOR Flash Command Sequencer

This block drives a parallel NOR flash bank whose devices take commands as short write sequences at fixed word offsets from the bank base. A client asks for one of four operations: read the identity codes, program one word, erase one sector, or return the bank to read mode. The sequencer issues every bus cycle the operation needs on a simple synchronous flash port. It then watches bit 7 of the read-back word until the device reports completion, and answers with a one-cycle done pulse that carries a result code and, for an identity read, the manufacturer and device codes.

The bus word may hold several devices side by side, one per 16-bit lane. Command bytes are placed in the low byte of every lane, and completion is only accepted when bit 7 agrees in every lane. Before a program the sequencer reads the target word and refuses the request when the new value would need a 0 turned into a 1. Erase polling starts only after a settling delay, and both program and erase polling give up after a limit counted in clock cycles. The bank base is sampled when a request is accepted and held for the whole operation.

Top module: `norflash_unlock_seq`

## Requirements
- R1: Every program, erase and identity operation begins with two writes: 0xAA at bank base + 0x555, then 0x55 at bank base + 0x2AA (word addresses).
- R2: A program (op code 1) writes 0xA0 at base + 0x555 after the unlock pair and then the data word at the target address. On success nothing further is written, and the result is 0.
- R3: A sector erase (op code 2) writes the unlock pair, 0x80 at base + 0x555, the unlock pair again and 0x30 at the target (sector) address. On completion it writes 0xF0 at the base, and the result is 0.
- R4: An identity read (op code 0) writes the unlock pair and 0x90 at base + 0x555. It then reads base + 0 and base + 1, reports bits 7:0 of the first word as the manufacturer code and the whole second word as the device code, and finally writes 0xF0 at the base.
- R5: A read-mode request (op code 3) produces exactly one write, 0xF0 at the base, and result 0.
- R6: A program is complete only when bit 7 of every lane of the read-back word equals bit 7 of the same lane of the data. An erase is complete only when bit 7 of every lane reads 1.
- R7: After the 0x30 write of an erase, no polling read starts until at least ERASE_WAIT clock cycles have passed.
- R8: A program whose target word, read first, has a 0 where the data has a 1 ends with result 2 and no write at all.
- R9: When polling exceeds PROG_TOUT (program) or ERASE_TOUT (erase) cycles, the sequencer writes 0xF0 at the target address and ends with result 1.
- R10: A command byte occupies bits 7:0 of every 16-bit lane, with all other bits 0 (0x00AA00AA on a 32-bit bus).
- R11: A request is taken only while req_ready is high. Done is a single-cycle pulse that carries the result, and req_ready is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 identity, 1 program, 2 sector erase, 3 read mode |
| req_addr | input | ADDR_W | Target word or sector address |
| req_data | input | DATA_W | Word to program |
| bank_base | input | ADDR_W | Word address of the bank base, sampled at acceptance |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we | output | 1 | Flash write cycle |
| fl_re | output | 1 | Flash read cycle; data returns on fl_rdata in the next cycle |
| fl_rdata | input | DATA_W | Flash read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 timeout, 2 target not erased |
| mfr_id | output | 8 | Manufacturer code from the last identity read |
| dev_id | output | DATA_W | Device code from the last identity read |

## Verification
The hardest case to reach from the ports is a two-device bus where one lane has finished and the other has not. A sequencer that looks at only one lane would then report success early. The bench's flash model has a partial-busy mode: during a program it inverts bit 7 of the upper lane only, and it never finishes. The correct result is therefore a timeout, while a design that checks only the low lane would report success. The erase settling delay is measured from the cycle stamp of the logged 0x30 write to the first read cycle that follows it.

// File: rtl/nfs_pkg.sv
// Shared types and constants for the unlock-cycle NOR flash sequencer.
// Assumes a data bus made of one or more lanes of LANE_W bits, at most 64 bits wide.
package nfs_pkg;

    typedef enum logic [1:0] {
        OP_IDENT  = 2'd0,
        OP_PROG   = 2'd1,
        OP_ERASE  = 2'd2,
        OP_RDMODE = 2'd3
    } nfs_op_e;

    localparam logic [1:0] RES_OK        = 2'd0;
    localparam logic [1:0] RES_TIMEOUT   = 2'd1;
    localparam logic [1:0] RES_NOT_BLANK = 2'd2;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_WRITE   = 8'hA0;
    localparam logic [7:0] CMD_ERS_ARM = 8'h80;
    localparam logic [7:0] CMD_ERS_SEC = 8'h30;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_RDMODE  = 8'hF0;

    localparam logic [11:0] OFS_KEY_A = 12'h555;
    localparam logic [11:0] OFS_KEY_B = 12'h2AA;

    typedef enum logic [3:0] {
        S_IDLE, S_BLANK_RD, S_BLANK_CHK, S_CMD, S_DELAY, S_POLL_RD, S_POLL_CHK,
        S_ID_RD0, S_ID_CHK0, S_ID_RD1, S_ID_CHK1, S_EXIT, S_FINISH
    } nfs_state_e;

    // Places a command byte in the low byte of every lane.
    function automatic logic [63:0] nfs_rep(input logic [7:0] b, input int lanes, input int lane_w);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < lanes; i++) begin
            v = v | ({56'd0, b} << (i * lane_w));
        end
        return v;
    endfunction

endpackage

// File: rtl/nfs_cmd_steps.sv
// Command step table: for a given operation and step index it gives the
// address and data of one write cycle, and flags the last step.
// Assumes the step index stays inside the sequence of the selected operation.
module nfs_cmd_steps
    import nfs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input  nfs_op_e             op,
    input  logic [2:0]          step,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   target,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                last_step,
    output logic                data_step
);
    localparam int LANES = DATA_W / LANE_W;

    typedef enum logic [1:0] {AS_KEY_A, AS_KEY_B, AS_TARGET, AS_BASE} addr_sel_e;

    addr_sel_e  asel;
    logic [7:0] cmd;

    // Choose the command byte and address kind of the current step.
    always_comb begin
        asel      = AS_KEY_A;
        cmd       = CMD_KEY_A;
        last_step = 1'b0;
        data_step = 1'b0;
        unique case (op)
            OP_PROG: begin
                unique case (step)
                    3'd0:    begin asel = AS_KEY_A; cmd = CMD_KEY_A; end
                    3'd1:    begin asel = AS_KEY_B; cmd = CMD_KEY_B; end
                    3'd2:    begin asel = AS_KEY_A; cmd = CMD_WRITE; end
                    default: begin asel = AS_TARGET; data_step = 1'b1; last_step = 1'b1; end
                endcase
            end
            OP_ERASE: begin
                unique case (step)
                    3'd0, 3'd3: begin asel = AS_KEY_A; cmd = CMD_KEY_A; end
                    3'd1, 3'd4: begin asel = AS_KEY_B; cmd = CMD_KEY_B; end
                    3'd2:       begin asel = AS_KEY_A; cmd = CMD_ERS_ARM; end
                    default:    begin asel = AS_TARGET; cmd = CMD_ERS_SEC; last_step = 1'b1; end
                endcase
            end
            OP_IDENT: begin
                unique case (step)
                    3'd0:    begin asel = AS_KEY_A; cmd = CMD_KEY_A; end
                    3'd1:    begin asel = AS_KEY_B; cmd = CMD_KEY_B; end
                    default: begin asel = AS_KEY_A; cmd = CMD_IDENT; last_step = 1'b1; end
                endcase
            end
            default: begin
                asel      = AS_BASE;
                cmd       = CMD_RDMODE;
                last_step = 1'b1;
            end
        endcase
    end

    // Form the bus address and the lane-replicated data word.
    always_comb begin
        unique case (asel)
            AS_KEY_A:  wr_addr = base + ADDR_W'(OFS_KEY_A);
            AS_KEY_B:  wr_addr = base + ADDR_W'(OFS_KEY_B);
            AS_TARGET: wr_addr = target;
            default:   wr_addr = base;
        endcase
        wr_data = data_step ? wdata : DATA_W'(nfs_rep(cmd, LANES, LANE_W));
    end

endmodule

// File: rtl/nfs_lane_check.sv
// Per-lane evaluation of a read-back word: bit-7 match for program,
// bit-7 set for erase, and the erased-enough test before programming.
// Assumes DATA_W is a whole multiple of LANE_W and LANE_W is at least 8.
module nfs_lane_check #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] rd,
    input  logic [DATA_W-1:0] wd,
    output logic              prog_match,
    output logic              erase_ready,
    output logic              blank_ok
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_pm;
    logic [LANES-1:0] lane_er;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Bit 7 of this lane against the written data and against 1.
        assign lane_pm[g] = (rd[g*LANE_W+7] == wd[g*LANE_W+7]);
        assign lane_er[g] = rd[g*LANE_W+7];
    end

    assign prog_match  = &lane_pm;
    assign erase_ready = &lane_er;
    assign blank_ok    = ((rd & wd) == wd);

endmodule

// File: rtl/nfs_cycle_timer.sv
// Saturating cycle counter cleared by a pulse; used for the erase settling
// delay and the polling limits. Assumes TW covers the largest limit.
module nfs_cycle_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);
    // Count up from a clear, holding at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/norflash_unlock_seq.sv
// Unlock-cycle NOR flash sequencer: takes one request at a time, issues the
// command writes, polls bit 7 for completion and reports a result code.
// Assumes a synchronous flash port whose read data is valid one cycle after fl_re.
module norflash_unlock_seq
    import nfs_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter int LANE_W     = 16,
    parameter int ERASE_WAIT = 100000,
    parameter int PROG_TOUT  = 20000,
    parameter int ERASE_TOUT = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ADDR_W-1:0] bank_base,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              done,
    output logic [1:0]        result,
    output logic [7:0]        mfr_id,
    output logic [DATA_W-1:0] dev_id
);
    localparam int LANES   = DATA_W / LANE_W;
    localparam int LIM_A   = (PROG_TOUT > ERASE_TOUT) ? PROG_TOUT : ERASE_TOUT;
    localparam int LIM_MAX = (LIM_A > ERASE_WAIT) ? LIM_A : ERASE_WAIT;
    localparam int TW      = $clog2(LIM_MAX + 2);
    localparam logic [DATA_W-1:0] RDMODE_WORD = DATA_W'(nfs_rep(CMD_RDMODE, LANES, LANE_W));
    localparam logic [DATA_W-1:0] LOW_BYTES   = DATA_W'(nfs_rep(8'hFF, LANES, LANE_W));

    nfs_state_e        state;
    nfs_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] exit_addr_q;
    logic [DATA_W-1:0] data_q;
    logic [2:0]        step_q;
    logic [1:0]        res_q;
    logic [7:0]        mfr_q;
    logic [DATA_W-1:0] dev_q;

    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic              st_last;
    logic              st_data_step;
    logic              prog_match;
    logic              erase_ready;
    logic              blank_ok;
    logic              tmr_clr;
    logic [TW-1:0]     tcnt;
    logic              wait_over;
    logic              poll_expired;
    logic              poll_finished;

    nfs_cmd_steps #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_steps (
        .op        (op_q),
        .step      (step_q),
        .base      (base_q),
        .target    (addr_q),
        .wdata     (data_q),
        .wr_addr   (st_addr),
        .wr_data   (st_data),
        .last_step (st_last),
        .data_step (st_data_step)
    );

    nfs_lane_check #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_check (
        .rd          (fl_rdata),
        .wd          (data_q),
        .prog_match  (prog_match),
        .erase_ready (erase_ready),
        .blank_ok    (blank_ok)
    );

    nfs_cycle_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tcnt)
    );

    // Timer restarts on the final command write; compare against the limits.
    assign tmr_clr       = (state == S_CMD) && st_last;
    assign wait_over     = (tcnt >= TW'(ERASE_WAIT));
    assign poll_expired  = (op_q == OP_PROG) ? (tcnt >= TW'(PROG_TOUT)) : (tcnt >= TW'(ERASE_TOUT));
    assign poll_finished = (op_q == OP_PROG) ? prog_match : erase_ready;

    // Main sequencing state machine and its registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            op_q        <= OP_RDMODE;
            addr_q      <= '0;
            base_q      <= '0;
            exit_addr_q <= '0;
            data_q      <= '0;
            step_q      <= '0;
            res_q       <= RES_OK;
            mfr_q       <= '0;
            dev_q       <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q   <= nfs_op_e'(req_op);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        base_q <= bank_base;
                        step_q <= '0;
                        state  <= (nfs_op_e'(req_op) == OP_PROG) ? S_BLANK_RD : S_CMD;
                    end
                end
                S_BLANK_RD: state <= S_BLANK_CHK;
                S_BLANK_CHK: begin
                    if (blank_ok) begin
                        state <= S_CMD;
                    end else begin
                        res_q <= RES_NOT_BLANK;
                        state <= S_FINISH;
                    end
                end
                S_CMD: begin
                    if (!st_last) begin
                        step_q <= step_q + 3'd1;
                    end else begin
                        unique case (op_q)
                            OP_PROG:  state <= S_POLL_RD;
                            OP_ERASE: state <= S_DELAY;
                            OP_IDENT: state <= S_ID_RD0;
                            default: begin
                                res_q <= RES_OK;
                                state <= S_FINISH;
                            end
                        endcase
                    end
                end
                S_DELAY: if (wait_over) state <= S_POLL_RD;
                S_POLL_RD: state <= S_POLL_CHK;
                S_POLL_CHK: begin
                    if (poll_finished) begin
                        res_q <= RES_OK;
                        if (op_q == OP_PROG) begin
                            state <= S_FINISH;
                        end else begin
                            exit_addr_q <= base_q;
                            state       <= S_EXIT;
                        end
                    end else if (poll_expired) begin
                        res_q       <= RES_TIMEOUT;
                        exit_addr_q <= addr_q;
                        state       <= S_EXIT;
                    end else begin
                        state <= S_POLL_RD;
                    end
                end
                S_ID_RD0: state <= S_ID_CHK0;
                S_ID_CHK0: begin
                    mfr_q <= fl_rdata[7:0];
                    state <= S_ID_RD1;
                end
                S_ID_RD1: state <= S_ID_CHK1;
                S_ID_CHK1: begin
                    dev_q       <= fl_rdata;
                    res_q       <= RES_OK;
                    exit_addr_q <= base_q;
                    state       <= S_EXIT;
                end
                S_EXIT:   state <= S_FINISH;
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Drive the flash port from the current state.
    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = addr_q;
        fl_wdata = '0;
        unique case (state)
            S_BLANK_RD, S_POLL_RD: fl_re = 1'b1;
            S_CMD: begin
                fl_we    = 1'b1;
                fl_addr  = st_addr;
                fl_wdata = st_data;
            end
            S_ID_RD0: begin
                fl_re   = 1'b1;
                fl_addr = base_q;
            end
            S_ID_RD1: begin
                fl_re   = 1'b1;
                fl_addr = base_q + ADDR_W'(1);
            end
            S_EXIT: begin
                fl_we    = 1'b1;
                fl_addr  = exit_addr_q;
                fl_wdata = RDMODE_WORD;
            end
            default: ;
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign done      = (state == S_FINISH);
    assign result    = res_q;
    assign mfr_id    = mfr_q;
    assign dev_id    = dev_q;

    // Tracks whether any write has been issued since the request was taken.
    logic wrote_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                       wrote_q <= 1'b0;
        else if (req_valid && req_ready)  wrote_q <= 1'b0;
        else if (fl_we)                   wrote_q <= 1'b1;
    end

    AST_NOT_BLANK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_NOT_BLANK) |-> !wrote_q); // R8

    AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TIMEOUT) |-> ($past(fl_we) && $past(fl_wdata) == RDMODE_WORD)); // R9

    AST_ERASE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_re && state == S_POLL_RD && op_q == OP_ERASE) |-> (tcnt >= TW'(ERASE_WAIT))); // R7

    AST_CMD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && !(state == S_CMD && st_data_step)) |-> ((fl_wdata & ~LOW_BYTES) == '0)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R11

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re)); // R11

endmodule

// File: tb/test_norflash_unlock_seq.sv
// Directed bench with a behavioural two-device flash model.
module test_norflash_unlock_seq;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int EW     = 20;
    localparam int PROG_BUSY  = 5;
    localparam int ERASE_BUSY = 40;
    localparam logic [23:0] BASE = 24'h010000;
    localparam logic [23:0] KA   = 24'h010555;
    localparam logic [23:0] KB   = 24'h0102AA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [ADDR_W-1:0] bank_base = BASE;
    logic [ADDR_W-1:0] fl_addr;
    logic [DATA_W-1:0] fl_wdata;
    logic fl_we, fl_re;
    logic [DATA_W-1:0] fl_rdata = '0;
    logic done;
    logic [1:0] result;
    logic [7:0] mfr_id;
    logic [DATA_W-1:0] dev_id;

    always #5 clk = ~clk;

    norflash_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(16),
        .ERASE_WAIT(EW), .PROG_TOUT(60), .ERASE_TOUT(150)) i_norflash_unlock_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .bank_base(bank_base),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .done(done), .result(result), .mfr_id(mfr_id), .dev_id(dev_id));

    // ---------------- flash model ----------------
    logic [31:0] mem [0:255];
    int   busy = 0;
    logic bprog = 1'b0;
    logic [31:0] bdata = '0;
    logic prog_armed = 1'b0, erase_armed = 1'b0, id_mode = 1'b0;
    logic stuck = 1'b0, partial = 1'b0;

    initial for (int k = 0; k < 256; k++) mem[k] = '1;

    always @(posedge clk) begin
        if (busy > 0) busy <= busy - 1;
        if (fl_we) begin
            if (prog_armed) begin
                mem[fl_addr[7:0]] <= mem[fl_addr[7:0]] & fl_wdata;
                busy <= stuck ? 1000000 : PROG_BUSY;
                bprog <= 1'b1; bdata <= fl_wdata; prog_armed <= 1'b0;
            end else begin
                case (fl_wdata[7:0])
                    8'hA0: prog_armed <= 1'b1;
                    8'h80: erase_armed <= 1'b1;
                    8'h30: if (erase_armed) begin
                        for (int k = 0; k < 256; k++) mem[k] <= '1;
                        busy <= stuck ? 1000000 : ERASE_BUSY;
                        bprog <= 1'b0; erase_armed <= 1'b0;
                    end
                    8'h90: id_mode <= 1'b1;
                    8'hF0: begin id_mode <= 1'b0; busy <= 0; end
                    default: ;
                endcase
            end
        end
        if (fl_re) begin
            logic [31:0] v;
            v = mem[fl_addr[7:0]];
            if (id_mode) begin
                v = (fl_addr == BASE) ? 32'hAB120001 : 32'h22D722D7;
            end else if (busy > 0) begin
                if (bprog) begin
                    v[23] = ~bdata[23];
                    if (!partial) v[7] = ~bdata[7];
                end else begin
                    v = v & ~32'h00800080;
                end
            end
            fl_rdata <= v;
        end
    end

    // ---------------- bus monitor ----------------
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [23:0] log_a [0:15];
    logic [31:0] log_d [0:15];
    int log_c [0:15];
    int log_n = 0;
    int rd_n = 0;
    int rd_first_c = 0;

    always @(negedge clk) begin
        if (fl_we && log_n < 16) begin
            log_a[log_n] = fl_addr; log_d[log_n] = fl_wdata; log_c[log_n] = cyc;
            log_n = log_n + 1;
        end
        if (fl_re) begin
            if (rd_n == 0) rd_first_c = cyc;
            rd_n = rd_n + 1;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;
    logic [1:0] got_res;
    logic [7:0] got_mfr;
    logic [31:0] got_dev;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rep(input logic [7:0] b);
        return {8'h00, b, 8'h00, b};
    endfunction

    task automatic chk_wr(input int i, input logic [23:0] a, input logic [31:0] d, input string tag);
        chk(log_a[i] == a && log_d[i] == d, tag, {8'h0, log_a[i], log_d[i]}, {8'h0, a, d});
    endtask

    task automatic run_req(input logic [1:0] op, input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        log_n = 0; rd_n = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got_res = result; got_mfr = mfr_id; got_dev = dev_id;
        @(negedge clk);
        chk(!done && req_ready, "R11 done is one cycle then ready", {62'd0, done, req_ready}, 64'd1);
    endtask

    task automatic t_reset_state();
        chk(req_ready && !done && !fl_we && !fl_re, "R11 reset state",
            {60'd0, req_ready, done, fl_we, fl_re}, 64'h8);
    endtask

    task automatic t_ident();
        run_req(2'd0, 24'h0, 32'h0);
        chk(log_n == 4, "R4 identity write count", log_n, 4);
        chk_wr(0, KA, rep(8'hAA), "R1 first unlock write");
        chk_wr(1, KB, rep(8'h55), "R1 second unlock write");
        chk_wr(2, KA, rep(8'h90), "R4 identity command");
        chk_wr(3, BASE, rep(8'hF0), "R4 read mode after identity");
        chk(got_mfr == 8'h01, "R4 manufacturer low byte", got_mfr, 8'h01);
        chk(got_dev == 32'h22D722D7, "R4 device word", got_dev, 32'h22D722D7);
        chk(got_res == 2'd0, "R4 result", got_res, 0);
    endtask

    task automatic t_rdmode();
        run_req(2'd3, 24'h0, 32'h0);
        chk(log_n == 1, "R5 single write", log_n, 1);
        chk_wr(0, BASE, rep(8'hF0), "R5 read mode word at base R10");
        chk(got_res == 2'd0, "R5 result", got_res, 0);
    endtask

    task automatic t_prog_ok();
        run_req(2'd1, 24'h010040, 32'h12345678);
        chk(log_n == 4, "R2 program write count", log_n, 4);
        chk_wr(2, KA, rep(8'hA0), "R2 program command");
        chk_wr(3, 24'h010040, 32'h12345678, "R2 data write");
        chk(got_res == 2'd0, "R2 R6 program result", got_res, 0);
        chk(mem[8'h40] == 32'h12345678, "R2 stored word", mem[8'h40], 32'h12345678);
    endtask

    task automatic t_not_blank();
        run_req(2'd1, 24'h010040, 32'hFFFF0000);
        chk(got_res == 2'd2, "R8 not-blank result", got_res, 2);
        chk(log_n == 0, "R8 no write issued", log_n, 0);
    endtask

    task automatic t_prog_timeout();
        stuck = 1'b1;
        run_req(2'd1, 24'h010041, 32'h00000000);
        stuck = 1'b0;
        chk(got_res == 2'd1, "R9 program timeout result", got_res, 1);
        chk_wr(log_n - 1, 24'h010041, rep(8'hF0), "R9 read mode at target");
    endtask

    task automatic t_lane_partial();
        stuck = 1'b1; partial = 1'b1;
        run_req(2'd1, 24'h010042, 32'h00800080);
        stuck = 1'b0; partial = 1'b0;
        chk(got_res == 2'd1, "R6 one lane still busy gives timeout", got_res, 1);
    endtask

    task automatic t_erase_ok();
        run_req(2'd2, 24'h010100, 32'h0);
        chk(log_n == 7, "R3 erase write count", log_n, 7);
        chk_wr(2, KA, rep(8'h80), "R3 erase arm");
        chk_wr(3, KA, rep(8'hAA), "R3 second unlock first");
        chk_wr(4, KB, rep(8'h55), "R3 second unlock second");
        chk_wr(5, 24'h010100, rep(8'h30), "R3 sector command");
        chk_wr(6, BASE, rep(8'hF0), "R3 read mode after erase");
        chk(got_res == 2'd0, "R3 R6 erase result", got_res, 0);
        chk(rd_first_c - log_c[5] >= EW, "R7 settling delay", rd_first_c - log_c[5], EW);
        chk(mem[8'h40] == 32'hFFFFFFFF, "R3 region erased", mem[8'h40], 32'hFFFFFFFF);
    endtask

    task automatic t_erase_timeout();
        stuck = 1'b1;
        run_req(2'd2, 24'h010100, 32'h0);
        stuck = 1'b0;
        chk(got_res == 2'd1, "R9 erase timeout result", got_res, 1);
        chk_wr(log_n - 1, 24'h010100, rep(8'hF0), "R9 read mode at sector");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ident();
        t_rdmode();
        t_prog_ok();
        t_not_blank();
        t_prog_timeout();
        t_lane_partial();
        t_erase_ok();
        t_erase_timeout();
        finish_run();
    end

endmodule